// File: doc/BRIEF.md
# External Memory Bus Bridge

This block connects an internal single-request port to an external asynchronous-style memory bus. The internal side offers a byte address, sixteen bits of write data, a two-bit byte mask and a read/write flag under a valid/ready handshake. It returns exactly one response pulse carrying read data and an error flag. The external side drives a 22-bit address, active-low byte enables, active-low write and output strobes, and four device selects. It also drives a sixteen-bit data bus with a per-lane driver enable. It waits for an active-low transfer acknowledge to end each cycle.

A live bus-width input narrows the data bus to its low byte lane. A request is locked to the width that is present when it is accepted. In narrow mode a full sixteen-bit access becomes two back-to-back byte cycles, and the two bytes are merged into one response. A programmable cycle counter ends a cycle that is never acknowledged. It pulses the abort output and flags the response as an error. The two top address bits choose the select line. Selects 1 to 3 each have a polarity bit with mixed reset defaults. Select 0 is always active low.

Top module: `xbus_bridge`

## Requirements
- R1: In wide mode (`bus_w8_n` high) an access is one bus cycle at the request address. `bus_eb_n[0]` is low exactly when `req_mask[1]` is set and qualifies data bits [15:8]. `bus_eb_n[1]` is low exactly when `req_mask[0]` is set and qualifies bits [7:0]. Write data is driven on the lanes the mask selects. Read data has masked-off bytes returned as zero.
- R2: While the bridge is narrow (`bus_w8_n` low when idle, or a narrow request in progress), `bus_eb_n` is 2'b01 and only the low data lane (`bus_dq_oe` 2'b01) can be driven.
- R3: In narrow mode a request with mask 2'b11 runs as two consecutive byte cycles. The first is at the even address and carries bits [15:8]. The second is at the odd address and carries bits [7:0]. Both use data lane [7:0], and only one response is returned, with both bytes merged.
- R4: In narrow mode a single-byte request runs one cycle. Mask 2'b10 uses the even address and bits [15:8]. Mask 2'b01 uses the odd address and bits [7:0].
- R5: Data drivers are enabled only during a write strobe. While `bus_oe_n` is low, `bus_dq_oe` is 2'b00.
- R6: A cycle holds its strobes and address while `bus_ta_n` is high. It ends at the clock edge where `bus_ta_n` is sampled low, and `rsp_valid` is high for one cycle after the last cycle ends.
- R7: If `bus_ta_n` stays high for the programmed limit plus one strobe cycles, the cycle ends. `bus_abort_n` goes low for one clock, together with `rsp_valid` and `rsp_err`. The reset limit is 255, which gives 256 strobe cycles.
- R8: Address bits [21:20] choose select 0 to 3 during a cycle. Select 0 is active low. Select k (1 to 3) is active high when its polarity bit (`cfg_sel_pol[k-1]`) is 1. After reset, select 3 is active high and selects 1 and 2 are active low.
- R9: While `bus_grant` is low, `bus_ctl_oe` is low, `bus_dq_oe` is 2'b00 and no request is accepted.
- R10: During and right after reset, both strobes are high, no data lane is driven, every select is at its inactive level, `bus_abort_n` is high, and `req_ready` is high once reset ends with the bus granted.
- R11: A `cfg_we` pulse loads the select polarity bits and the timeout limit. Later cycles use the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask, bit 1 = bits [15:8], bit 0 = bits [7:0] |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 16 | Read result |
| rsp_err | output | 1 | Response ended by timeout |
| cfg_we | input | 1 | Load configuration |
| cfg_sel_pol | input | 3 | Polarity of selects 3..1, 1 = active high |
| cfg_timeout | input | 8 | Acknowledge wait limit |
| bus_grant | input | 1 | External bus granted to this bridge |
| bus_w8_n | input | 1 | Low selects the narrow bus |
| bus_ctl_oe | output | 1 | Enable for address, byte enable and strobe drivers |
| bus_addr | output | 22 | Bus address |
| bus_eb_n | output | 2 | Byte enables, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_oe_n | output | 1 | Output enable strobe, active low |
| bus_sel | output | 4 | Device selects |
| bus_dq_o | output | 16 | Data out |
| bus_dq_oe | output | 2 | Data driver enable per lane, bit 1 = [15:8] |
| bus_dq_i | input | 16 | Data in |
| bus_ta_n | input | 1 | Transfer acknowledge, active low |
| bus_abort_n | output | 1 | Abort pulse, active low |

## Verification
The hardest situation to reach is the timeout abort at its reset limit. It needs an acknowledge held off for 256 strobe cycles while everything else stays quiet. The bench holds the acknowledge high without limit and counts strobe cycles up to the response. It then reloads a short limit with new polarities and repeats the run, confirming the new count and the new select levels. The narrow two-beat merge is reached by switching the width input between table rows. A bus model returns address-derived bytes, so the order and placement of each byte can be seen in the merged result.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    parameter int XB_ADDR_W = 22;
    parameter int XB_LANE_W = 8;
    parameter int XB_NSEL   = 4;
    parameter int XB_TMO_W  = 8;

    typedef enum logic {
        XB_IDLE   = 1'b0,
        XB_ACCESS = 1'b1
    } xb_state_e;
endpackage

// File: rtl/xbus_timeout.sv
module xbus_timeout #(
    parameter int                CNT_W     = 8,
    parameter logic [CNT_W-1:0]  RST_LIMIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic             run,
    output logic             expired
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] limit;
    } tmo_t;

    tmo_t tq, td;

    always_comb begin
        td = tq;
        if (cfg_we) td.limit = cfg_limit;
        if (!run || expired) td.cnt = '0;
        else                 td.cnt = tq.cnt + 1'b1;
    end

    assign expired = run && (tq.cnt == tq.limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tq.cnt   <= '0;
            tq.limit <= RST_LIMIT;
        end else begin
            tq <= td;
        end
    end

    // R7: the wait counter never passes the limit
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tq.cnt <= tq.limit || !run);
endmodule

// File: rtl/xbus_sel_unit.sv
module xbus_sel_unit #(
    parameter int                NSEL    = 4,
    parameter logic [NSEL-2:0]   POL_RST = 3'b100,
    localparam int               SEL_W   = $clog2(NSEL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [NSEL-2:0]  cfg_pol,
    input  logic             active,
    input  logic [SEL_W-1:0] idx,
    output logic [NSEL-1:0]  sel
);
    logic [NSEL-2:0] pol_q, pol_d;

    always_comb begin
        pol_d = pol_q;
        if (cfg_we) pol_d = cfg_pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pol_q <= POL_RST;
        else        pol_q <= pol_d;
    end

    for (genvar k = 0; k < NSEL; k++) begin : g_sel
        logic hit;
        assign hit = active && (idx == SEL_W'(k));
        if (k == 0) begin : g_fixed
            assign sel[k] = !hit;
        end else begin : g_prog
            assign sel[k] = hit ? pol_q[k-1] : !pol_q[k-1];
        end
    end

    // R8: outside a cycle select 0 rests high
    a_r8_sel0_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> sel[0]);
    // R8: at most one select leaves its resting level
    a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel ^ {~pol_q, 1'b1}) <= 1);
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
    import xbus_pkg::*;
#(
    parameter int ADDR_W = XB_ADDR_W,
    parameter int LANE_W = XB_LANE_W,
    parameter int NSEL   = XB_NSEL,
    parameter int TMO_W  = XB_TMO_W,
    localparam int DATA_W = 2 * LANE_W,
    localparam int SEL_W  = $clog2(NSEL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    input  logic              cfg_we,
    input  logic [NSEL-2:0]   cfg_sel_pol,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic              bus_grant,
    input  logic              bus_w8_n,
    output logic              bus_ctl_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_eb_n,
    output logic              bus_we_n,
    output logic              bus_oe_n,
    output logic [NSEL-1:0]   bus_sel,
    output logic [DATA_W-1:0] bus_dq_o,
    output logic [1:0]        bus_dq_oe,
    input  logic [DATA_W-1:0] bus_dq_i,
    input  logic              bus_ta_n,
    output logic              bus_abort_n
);
    typedef struct packed {
        xb_state_e         st;
        logic              wr;
        logic              nar;
        logic              second;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        mask;
        logic [DATA_W-1:0] rdata;
        logic              rsp_v;
        logic              rsp_e;
        logic              abort;
    } ctl_t;

    ctl_t cq, cd;
    logic in_cyc, tmo_hit, hi_byte, narrow_now;

    assign in_cyc  = (cq.st == XB_ACCESS);
    assign hi_byte = !cq.addr[0];

    xbus_timeout #(.CNT_W(TMO_W), .RST_LIMIT('1)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_limit (cfg_timeout),
        .run       (in_cyc && bus_ta_n),
        .expired   (tmo_hit)
    );

    xbus_sel_unit #(.NSEL(NSEL), .POL_RST(3'b100)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_pol (cfg_sel_pol),
        .active  (in_cyc),
        .idx     (cq.addr[ADDR_W-1 -: SEL_W]),
        .sel     (bus_sel)
    );

    always_comb begin
        cd       = cq;
        cd.rsp_v = 1'b0;
        cd.rsp_e = 1'b0;
        cd.abort = 1'b0;
        unique case (cq.st)
            XB_IDLE: begin
                if (req_valid && req_ready) begin
                    cd.st     = XB_ACCESS;
                    cd.wr     = req_write;
                    cd.nar    = !bus_w8_n;
                    cd.second = 1'b0;
                    cd.wdata  = req_wdata;
                    cd.mask   = req_mask;
                    cd.rdata  = '0;
                    if (bus_w8_n)              cd.addr = req_addr;
                    else if (req_mask == 2'b01) cd.addr = {req_addr[ADDR_W-1:1], 1'b1};
                    else                        cd.addr = {req_addr[ADDR_W-1:1], 1'b0};
                end
            end
            XB_ACCESS: begin
                if (tmo_hit) begin
                    cd.st    = XB_IDLE;
                    cd.rsp_v = 1'b1;
                    cd.rsp_e = 1'b1;
                    cd.abort = 1'b1;
                end else if (!bus_ta_n) begin
                    if (!cq.wr) begin
                        if (!cq.nar)
                            cd.rdata = bus_dq_i & {{LANE_W{cq.mask[1]}}, {LANE_W{cq.mask[0]}}};
                        else if (hi_byte)
                            cd.rdata[DATA_W-1:LANE_W] = bus_dq_i[LANE_W-1:0];
                        else
                            cd.rdata[LANE_W-1:0] = bus_dq_i[LANE_W-1:0];
                    end
                    if (cq.nar && cq.mask == 2'b11 && !cq.second) begin
                        cd.second  = 1'b1;
                        cd.addr[0] = 1'b1;
                    end else begin
                        cd.st    = XB_IDLE;
                        cd.rsp_v = 1'b1;
                    end
                end
            end
            default: cd.st = XB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq <= '{st: XB_IDLE, default: '0};
        end else begin
            cq <= cd;
        end
    end

    assign narrow_now  = in_cyc ? cq.nar : !bus_w8_n;
    assign req_ready   = bus_grant && (cq.st == XB_IDLE);
    assign bus_ctl_oe  = bus_grant;
    assign bus_addr    = cq.addr;
    assign bus_we_n    = !(in_cyc && cq.wr);
    assign bus_oe_n    = !(in_cyc && !cq.wr);
    assign bus_eb_n    = narrow_now ? 2'b01 :
                         in_cyc     ? {~cq.mask[0], ~cq.mask[1]} : 2'b11;
    assign bus_dq_oe   = (bus_grant && in_cyc && cq.wr) ? (cq.nar ? 2'b01 : cq.mask) : 2'b00;
    assign bus_dq_o    = !cq.nar ? cq.wdata :
                         {{LANE_W{1'b0}}, hi_byte ? cq.wdata[DATA_W-1:LANE_W] : cq.wdata[LANE_W-1:0]};
    assign bus_abort_n = !cq.abort;
    assign rsp_valid   = cq.rsp_v;
    assign rsp_rdata   = cq.rdata;
    assign rsp_err     = cq.rsp_e;

    // R5: no data driver while the output strobe is asserted
    a_r5_quiet_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> bus_dq_oe == 2'b00);
    // R2: narrow cycles only drive the low lane
    a_r2_low_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n && bus_eb_n == 2'b01) |-> !bus_dq_oe[1]);
    // R6: an unacknowledged cycle keeps its address and strobes
    a_r6_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cyc && bus_ta_n && !tmo_hit) |=> (in_cyc && $stable(bus_addr) && $stable(bus_we_n)));
    // R7: abort lasts one clock and carries an error response
    a_r7_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_abort_n |=> bus_abort_n);
    a_r7_abort_err: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_abort_n |-> (rsp_valid && rsp_err));
    // R3: one response per request
    a_r3_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9: released bus drives no data
    a_r9_no_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_grant |-> (bus_dq_oe == 2'b00 && !req_ready));
endmodule

// File: tb/xbus_bridge_tb.sv
`timescale 1ns/1ps
module xbus_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = 2'b11;
    logic        rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel_pol = '0;
    logic [7:0]  cfg_timeout = '0;
    logic        bus_grant = 1'b1, bus_w8_n = 1'b1;
    logic        bus_ctl_oe, bus_we_n, bus_oe_n, bus_abort_n;
    logic [21:0] bus_addr;
    logic [1:0]  bus_eb_n, bus_dq_oe;
    logic [3:0]  bus_sel;
    logic [15:0] bus_dq_o, bus_dq_i;
    logic        bus_ta_n = 1'b1;

    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    assign bus_dq_i = {bus_addr[7:0] ^ 8'hA5, bus_addr[7:0] ^ 8'h3C};

    xbus_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cfg_we(cfg_we), .cfg_sel_pol(cfg_sel_pol), .cfg_timeout(cfg_timeout),
        .bus_grant(bus_grant), .bus_w8_n(bus_w8_n), .bus_ctl_oe(bus_ctl_oe),
        .bus_addr(bus_addr), .bus_eb_n(bus_eb_n), .bus_we_n(bus_we_n),
        .bus_oe_n(bus_oe_n), .bus_sel(bus_sel), .bus_dq_o(bus_dq_o),
        .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i), .bus_ta_n(bus_ta_n),
        .bus_abort_n(bus_abort_n)
    );

    typedef struct packed {
        logic        wr;
        logic        nar;
        logic [21:0] addr;
        logic [15:0] wdata;
        logic [1:0]  mask;
        logic [3:0]  ta_wait;
        logic [1:0]  beats;
        logic [21:0] a0;
        logic [21:0] a1;
        logic [15:0] d0;
        logic [15:0] d1;
        logic [1:0]  eb;
        logic [1:0]  oe;
        logic [3:0]  sel;
        logic [15:0] rdata;
        logic [3:0]  strobes;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,1'b0,22'h000010,16'hBEEF,2'b11,4'd0,2'd1,22'h000010,22'h0,16'hBEEF,16'h0,2'b00,2'b11,4'b0110,16'h0000,4'd1},
        '{1'b0,1'b0,22'h100022,16'h0000,2'b11,4'd0,2'd1,22'h100022,22'h0,16'h0000,16'h0,2'b00,2'b00,4'b0101,16'h871E,4'd1},
        '{1'b1,1'b0,22'h200031,16'h1234,2'b01,4'd0,2'd1,22'h200031,22'h0,16'h1234,16'h0,2'b01,2'b01,4'b0011,16'h0000,4'd1},
        '{1'b0,1'b0,22'h300040,16'h0000,2'b10,4'd0,2'd1,22'h300040,22'h0,16'h0000,16'h0,2'b10,2'b00,4'b1111,16'hE500,4'd1},
        '{1'b1,1'b1,22'h000051,16'hCAFE,2'b11,4'd0,2'd2,22'h000050,22'h000051,16'h00CA,16'h00FE,2'b01,2'b01,4'b0110,16'h0000,4'd2},
        '{1'b0,1'b1,22'h100060,16'h0000,2'b11,4'd0,2'd2,22'h100060,22'h100061,16'h0000,16'h0,2'b01,2'b00,4'b0101,16'h5C5D,4'd2},
        '{1'b0,1'b1,22'h000070,16'h0000,2'b01,4'd0,2'd1,22'h000071,22'h0,16'h0000,16'h0,2'b01,2'b00,4'b0110,16'h004D,4'd1},
        '{1'b1,1'b1,22'h000081,16'hAB12,2'b10,4'd0,2'd1,22'h000080,22'h0,16'h00AB,16'h0,2'b01,2'b01,4'b0110,16'h0000,4'd1},
        '{1'b0,1'b0,22'h000090,16'h0000,2'b11,4'd3,2'd1,22'h000090,22'h0,16'h0000,16'h0,2'b00,2'b00,4'b0110,16'h35AC,4'd4}
    };

    // results of the last access
    int          r_beats, r_strobes, r_aborts;
    logic [21:0] r_a [2];
    logic [15:0] r_d [2];
    logic [1:0]  r_eb, r_oe;
    logic [3:0]  r_sel;
    logic [15:0] r_rdata;
    logic        r_err;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] lanes(input logic [1:0] oe);
        return {{8{oe[1]}}, {8{oe[0]}}};
    endfunction

    task automatic run_access(input logic wr, input logic nar, input logic [21:0] addr,
                              input logic [15:0] wdata, input logic [1:0] mask, input int ta_wait);
        int  wcnt = 0;
        bit  done = 0;
        r_beats = 0; r_strobes = 0; r_aborts = 0; r_err = 0; r_rdata = '0;
        r_a[0] = '0; r_a[1] = '0; r_d[0] = '0; r_d[1] = '0;
        r_eb = '0; r_oe = '0; r_sel = '0;
        @(negedge clk);
        bus_w8_n  = !nar;
        req_write = wr; req_addr = addr; req_wdata = wdata; req_mask = mask;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 2000 && !done; i++) begin
            if (rsp_valid) begin
                r_rdata = rsp_rdata;
                r_err   = rsp_err;
                if (!bus_abort_n) r_aborts++;
                done = 1;
            end else if (!bus_we_n || !bus_oe_n) begin
                r_strobes++;
                if (wcnt >= ta_wait) begin
                    bus_ta_n = 1'b0;
                    if (r_beats < 2) begin
                        r_a[r_beats] = bus_addr;
                        r_d[r_beats] = bus_dq_o & lanes(bus_dq_oe);
                    end
                    if (r_beats == 0) begin
                        r_eb = bus_eb_n; r_oe = bus_dq_oe; r_sel = bus_sel;
                    end
                    r_beats++;
                    wcnt = 0;
                end else begin
                    bus_ta_n = 1'b1;
                    wcnt++;
                    if (r_beats == 0) begin
                        r_eb = bus_eb_n; r_oe = bus_dq_oe; r_sel = bus_sel;
                    end
                end
                @(negedge clk);
            end else begin
                bus_ta_n = 1'b1;
                @(negedge clk);
            end
        end
        bus_ta_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        string tag;
        // R10: state held in reset
        repeat (3) @(negedge clk);
        chk("R10", "we_n in reset", bus_we_n, 1);
        chk("R10", "oe_n in reset", bus_oe_n, 1);
        chk("R10", "dq_oe in reset", bus_dq_oe, 2'b00);
        chk("R10", "sel in reset", bus_sel, 4'b0111);
        chk("R10", "abort_n in reset", bus_abort_n, 1);
        chk("R1", "eb_n idle wide", bus_eb_n, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "ready after reset", req_ready, 1);

        // R2: narrow input forces byte-enable pattern even when idle
        bus_w8_n = 1'b0;
        @(negedge clk);
        chk("R2", "eb_n idle narrow", bus_eb_n, 2'b01);
        bus_w8_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            run_access(VECS[v].wr, VECS[v].nar, VECS[v].addr, VECS[v].wdata, VECS[v].mask, int'(VECS[v].ta_wait));
            tag = !VECS[v].nar ? "R1" : (VECS[v].mask == 2'b11 ? "R3" : "R4");
            chk(tag, "beats", r_beats, VECS[v].beats);
            chk(tag, "addr beat0", r_a[0], VECS[v].a0);
            if (VECS[v].beats == 2) chk("R3", "addr beat1", r_a[1], VECS[v].a1);
            chk(VECS[v].nar ? "R2" : "R1", "eb_n", r_eb, VECS[v].eb);
            chk("R5", "dq_oe", r_oe, VECS[v].oe);
            chk("R8", "select levels", r_sel, VECS[v].sel);
            chk("R6", "strobe cycles", r_strobes, VECS[v].strobes);
            chk(tag, "rsp_err", r_err, 0);
            if (VECS[v].wr) begin
                chk(tag, "wdata beat0", r_d[0], VECS[v].d0 & lanes(VECS[v].oe));
                if (VECS[v].beats == 2) chk("R3", "wdata beat1", r_d[1], VECS[v].d1);
            end else begin
                chk(tag, "rdata", r_rdata, VECS[v].rdata);
            end
        end

        // R9: no grant, no acceptance, no drive
        @(negedge clk);
        bus_grant = 1'b0;
        bus_w8_n = 1'b1;
        req_write = 1'b1; req_addr = 22'h000100; req_wdata = 16'h5555; req_mask = 2'b11;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "ready without grant", req_ready, 0);
        chk("R9", "ctl_oe without grant", bus_ctl_oe, 0);
        chk("R9", "we_n without grant", bus_we_n, 1);
        chk("R9", "dq_oe without grant", bus_dq_oe, 2'b00);
        req_valid = 1'b0;
        bus_grant = 1'b1;
        run_access(1'b1, 1'b0, 22'h000100, 16'h5555, 2'b11, 0);
        chk("R9", "beats after grant", r_beats, 1);

        // R7: default limit, 256 unacknowledged strobe cycles
        run_access(1'b0, 1'b0, 22'h000200, 16'h0, 2'b11, 100000);
        chk("R7", "default timeout strobes", r_strobes, 256);
        chk("R7", "abort with response", r_aborts, 1);
        chk("R7", "error flag", r_err, 1);
        chk("R7", "beats on abort", r_beats, 0);
        @(negedge clk);
        chk("R7", "abort released", bus_abort_n, 1);
        chk("R7", "strobe released", bus_oe_n, 1);

        // R11: reconfigure polarities and limit
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel_pol = 3'b011; cfg_timeout = 8'd5;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R11", "idle selects after reload", bus_sel, 4'b1001);
        run_access(1'b0, 1'b0, 22'h100000, 16'h0, 2'b11, 100000);
        chk("R11", "short timeout strobes", r_strobes, 6);
        chk("R11", "select1 active high", r_sel, 4'b1011);
        chk("R7", "short timeout error", r_err, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule